// File: doc/BRIEF.md
# Debug Pin Sharing Controller

This block decides, for each of five shared pads, whether the pad serves the on-chip debug port or general-purpose I/O. A small ownership state machine follows a 3-bit selection field that software writes after reset. It has three modes. Full debug keeps all five pads. Serial-wire-only debug keeps the clock pad and the mode/data pad and hands the other three to GPIO. Free mode hands every pad to GPIO. The block drives output enable, output value and pull-up/pull-down controls for each pad. It also routes each pad's input level either to the debug logic or to the GPIO input path.

GPIO mode and output writes are always captured in per-pad shadow registers. While debug owns a pad, those writes do not reach the pad. The stored setting takes over on the clock edge that releases the pad. Each debug-owned pad has its own fixed default: a pull-up, a pull-down or a tristated output.

Pad index order used throughout: bit 0 = mode/data pad (MSEL), bit 1 = debug clock pad (DCLK), bit 2 = debug data-in pad (DIN), bit 3 = debug data-out pad (DOUT), bit 4 = test-reset pad (TRST, active low).

The ownership state machine has four states:
- OS_RESET is held while `rst_n` is low.
- OS_FULL owns all five pads.
- OS_WIRE owns MSEL and DCLK only.
- OS_FREE owns no pad.

The transitions are:
- OS_RESET moves to OS_FULL at the first edge after reset, or to the decoded mode if a selection write arrives on that edge.
- From any other state, a write of 3'b010 moves to OS_WIRE.
- A write of 3'b100 moves to OS_FREE.
- A write of any other value moves to OS_FULL.
- With no write, the state holds.

Top module: `dbg_pin_share_ctrl`

## Requirements
- R1: While `rst_n` is low, and afterwards until the first selection write, all five pads are debug-owned and the GPIO shadow holds mode 2'b00 with output 0.
- R2: A selection write of 3'b010 makes MSEL and DCLK debug-owned and releases DIN, DOUT and TRST to GPIO, starting right after the capturing clock edge.
- R3: The defaults for debug-owned pads are as follows. MSEL, DIN and TRST have `pad_pu`=1, `pad_pd`=0 and `pad_oe`=0, except that MSEL may drive in serial-wire mode. DCLK has `pad_pd`=1, `pad_pu`=0 and `pad_oe`=0. DOUT has no pull.
- R4: A GPIO mode or output write to a debug-owned pad leaves that pad's `pad_oe`, `pad_o`, `pad_pu` and `pad_pd` unchanged.
- R5: In serial-wire mode, MSEL and DCLK stay with debug, and MSEL's `pad_oe`/`pad_o` follow `dbg_swd_oe`/`dbg_swd_o`. In full mode, MSEL never drives.
- R6: A selection write of 3'b100 releases all five pads to GPIO after the capturing edge.
- R7: A selection write of 3'b000, 3'b001, 3'b011, 3'b101, 3'b110 or 3'b111 returns all five pads to debug ownership, from any mode.
- R8: A released pad uses its stored GPIO setting from the edge that releases it, including a GPIO write captured on that same edge.
- R9: The GPIO encoding on a released pad is: mode 2'b00 floats, 2'b01 enables the pull-up, 2'b10 enables the pull-down, and 2'b11 drives `pad_o` = stored output with `pad_oe`=1. In the non-driving modes `pad_o`=0.
- R10: For a debug-owned pad, `dbg_in` = `pad_i` and `gpio_in` = 0. For a released pad, `gpio_in` = `pad_i` and `dbg_in` shows the idle level: 1 for MSEL, DIN and TRST, and 0 for DCLK and DOUT. The routing is combinational.
- R11: In full mode, DOUT's `pad_oe`/`pad_o` follow `dbg_dout_oe`/`dbg_dout` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| cfg_wr_en | input | 1 | Selection-field write strobe |
| cfg_wr_data | input | 3 | Selection value |
| gpio_wr_en | input | 5 | Per-pad GPIO shadow write strobes |
| gpio_mode_wr | input | 2 | GPIO mode written to the strobed pads |
| gpio_out_wr | input | 1 | GPIO output value written to the strobed pads |
| dbg_dout | input | 1 | Debug data-out value |
| dbg_dout_oe | input | 1 | Debug data-out enable |
| dbg_swd_o | input | 1 | Serial-wire data value toward MSEL |
| dbg_swd_oe | input | 1 | Serial-wire data output enable |
| pad_i | input | 5 | Pad input levels |
| pad_oe | output | 5 | Pad output enables |
| pad_o | output | 5 | Pad output values |
| pad_pu | output | 5 | Pad pull-up enables |
| pad_pd | output | 5 | Pad pull-down enables |
| dbg_in | output | 5 | Pad levels seen by the debug logic |
| gpio_in | output | 5 | Pad levels seen by GPIO input |

## Verification
The debug-signal paths and the pad-input routing are combinational, so their results are due in the same cycle as the stimulus. Selection and GPIO shadow writes pass through one register each, so their effect is due one edge after capture. The bench applies every stimulus at a falling edge. It lets the next rising edge capture the stimulus, then compares all six output vectors at the following falling edge against a model that it updates at that rising edge. Doing so covers both the one-edge and the same-cycle results without racing the clock.

// File: rtl/dps_pkg.sv
package dps_pkg;

    localparam int NPINS = 5;
    localparam int CFG_W = 3;
    localparam int MODE_W = 2;

    // Pad roles by index
    localparam int PIN_MSEL = 0;
    localparam int PIN_DCLK = 1;
    localparam int PIN_DIN  = 2;
    localparam int PIN_DOUT = 3;
    localparam int PIN_TRST = 4;

    typedef enum logic [1:0] {
        OS_RESET,
        OS_FULL,
        OS_WIRE,
        OS_FREE
    } own_state_e;

    localparam logic [CFG_W-1:0] CFG_WIRE = 3'b010;
    localparam logic [CFG_W-1:0] CFG_FREE = 3'b100;

    localparam logic [MODE_W-1:0] GM_FLOAT  = 2'b00;
    localparam logic [MODE_W-1:0] GM_PULLUP = 2'b01;
    localparam logic [MODE_W-1:0] GM_PULLDN = 2'b10;
    localparam logic [MODE_W-1:0] GM_DRIVE  = 2'b11;

    localparam logic [NPINS-1:0] MASK_ALL  = {NPINS{1'b1}};
    localparam logic [NPINS-1:0] MASK_NONE = '0;
    localparam logic [NPINS-1:0] MASK_WIRE =
        NPINS'((1 << PIN_MSEL) | (1 << PIN_DCLK));

    // Level shown to debug logic for a pad it does not own
    localparam logic [NPINS-1:0] IDLE_LEVEL =
        NPINS'((1 << PIN_MSEL) | (1 << PIN_DIN) | (1 << PIN_TRST));

endpackage

// File: rtl/dps_own_fsm.sv
module dps_own_fsm
    import dps_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_wr_en,
    input  logic [CFG_W-1:0]       cfg_wr_data,
    output logic [NPINS-1:0]       own_mask,
    output logic                   wire_mode
);

    own_state_e state_q;
    own_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OS_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OS_RESET: state_d = OS_FULL;
            OS_FULL:  state_d = OS_FULL;
            OS_WIRE:  state_d = OS_WIRE;
            OS_FREE:  state_d = OS_FREE;
        endcase
        if (cfg_wr_en) begin
            if (cfg_wr_data == CFG_WIRE) begin
                state_d = OS_WIRE;
            end else if (cfg_wr_data == CFG_FREE) begin
                state_d = OS_FREE;
            end else begin
                state_d = OS_FULL;
            end
        end
    end

    // Outputs
    always_comb begin
        own_mask  = MASK_ALL;
        wire_mode = 1'b0;
        unique case (state_q)
            OS_RESET: begin
                own_mask  = MASK_ALL;
                wire_mode = 1'b0;
            end
            OS_FULL: begin
                own_mask  = MASK_ALL;
                wire_mode = 1'b0;
            end
            OS_WIRE: begin
                own_mask  = MASK_WIRE;
                wire_mode = 1'b1;
            end
            OS_FREE: begin
                own_mask  = MASK_NONE;
                wire_mode = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/dps_gpio_shadow.sv
module dps_gpio_shadow
    import dps_pkg::*;
#(
    parameter int N = NPINS
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N-1:0]                 wr_en,
    input  logic [MODE_W-1:0]            mode_wr,
    input  logic                         out_wr,
    output logic [N-1:0][MODE_W-1:0]     mode_q,
    output logic [N-1:0]                 out_q
);

    for (genvar p = 0; p < N; p++) begin : g_pin
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mode_q[p] <= GM_FLOAT;
                out_q[p]  <= 1'b0;
            end else if (wr_en[p]) begin
                mode_q[p] <= mode_wr;
                out_q[p]  <= out_wr;
            end
        end
    end

endmodule

// File: rtl/dps_pad_mux.sv
module dps_pad_mux
    import dps_pkg::*;
(
    input  logic [NPINS-1:0]             own_mask,
    input  logic                         wire_mode,
    input  logic [NPINS-1:0][MODE_W-1:0] mode_q,
    input  logic [NPINS-1:0]             out_q,
    input  logic                         dbg_dout,
    input  logic                         dbg_dout_oe,
    input  logic                         dbg_swd_o,
    input  logic                         dbg_swd_oe,
    input  logic [NPINS-1:0]             pad_i,
    output logic [NPINS-1:0]             pad_oe,
    output logic [NPINS-1:0]             pad_o,
    output logic [NPINS-1:0]             pad_pu,
    output logic [NPINS-1:0]             pad_pd,
    output logic [NPINS-1:0]             dbg_in,
    output logic [NPINS-1:0]             gpio_in
);

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic d_oe, d_o, d_pu, d_pd;
        logic g_oe, g_o, g_pu, g_pd;

        // Debug-side defaults per pad role
        if (p == PIN_MSEL) begin : g_msel
            always_comb begin
                d_oe = wire_mode & dbg_swd_oe;
                d_o  = wire_mode & dbg_swd_o;
                d_pu = 1'b1;
                d_pd = 1'b0;
            end
        end else if (p == PIN_DCLK) begin : g_dclk
            always_comb begin
                d_oe = 1'b0;
                d_o  = 1'b0;
                d_pu = 1'b0;
                d_pd = 1'b1;
            end
        end else if (p == PIN_DOUT) begin : g_dout
            always_comb begin
                d_oe = dbg_dout_oe;
                d_o  = dbg_dout;
                d_pu = 1'b0;
                d_pd = 1'b0;
            end
        end else begin : g_pullup
            always_comb begin
                d_oe = 1'b0;
                d_o  = 1'b0;
                d_pu = 1'b1;
                d_pd = 1'b0;
            end
        end

        // GPIO-side decode of the stored setting
        always_comb begin
            g_oe = (mode_q[p] == GM_DRIVE);
            g_o  = (mode_q[p] == GM_DRIVE) & out_q[p];
            g_pu = (mode_q[p] == GM_PULLUP);
            g_pd = (mode_q[p] == GM_PULLDN);
        end

        assign pad_oe[p]  = own_mask[p] ? d_oe : g_oe;
        assign pad_o[p]   = own_mask[p] ? d_o  : g_o;
        assign pad_pu[p]  = own_mask[p] ? d_pu : g_pu;
        assign pad_pd[p]  = own_mask[p] ? d_pd : g_pd;
        assign dbg_in[p]  = own_mask[p] ? pad_i[p] : IDLE_LEVEL[p];
        assign gpio_in[p] = own_mask[p] ? 1'b0 : pad_i[p];
    end

endmodule

// File: rtl/dbg_pin_share_ctrl.sv
module dbg_pin_share_ctrl
    import dps_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr_en,
    input  logic [CFG_W-1:0]     cfg_wr_data,
    input  logic [NPINS-1:0]     gpio_wr_en,
    input  logic [MODE_W-1:0]    gpio_mode_wr,
    input  logic                 gpio_out_wr,
    input  logic                 dbg_dout,
    input  logic                 dbg_dout_oe,
    input  logic                 dbg_swd_o,
    input  logic                 dbg_swd_oe,
    input  logic [NPINS-1:0]     pad_i,
    output logic [NPINS-1:0]     pad_oe,
    output logic [NPINS-1:0]     pad_o,
    output logic [NPINS-1:0]     pad_pu,
    output logic [NPINS-1:0]     pad_pd,
    output logic [NPINS-1:0]     dbg_in,
    output logic [NPINS-1:0]     gpio_in
);

    logic [NPINS-1:0]             own_mask;
    logic                         wire_mode;
    logic [NPINS-1:0][MODE_W-1:0] mode_q;
    logic [NPINS-1:0]             out_q;

    dps_own_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_data (cfg_wr_data),
        .own_mask    (own_mask),
        .wire_mode   (wire_mode)
    );

    dps_gpio_shadow #(.N(NPINS)) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (gpio_wr_en),
        .mode_wr (gpio_mode_wr),
        .out_wr  (gpio_out_wr),
        .mode_q  (mode_q),
        .out_q   (out_q)
    );

    dps_pad_mux u_mux (
        .own_mask    (own_mask),
        .wire_mode   (wire_mode),
        .mode_q      (mode_q),
        .out_q       (out_q),
        .dbg_dout    (dbg_dout),
        .dbg_dout_oe (dbg_dout_oe),
        .dbg_swd_o   (dbg_swd_o),
        .dbg_swd_oe  (dbg_swd_oe),
        .pad_i       (pad_i),
        .pad_oe      (pad_oe),
        .pad_o       (pad_o),
        .pad_pu      (pad_pu),
        .pad_pd      (pad_pd),
        .dbg_in      (dbg_in),
        .gpio_in     (gpio_in)
    );

endmodule

// File: rtl/dps_checker.sv
module dps_checker
    import dps_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cfg_wr_en,
    input logic [CFG_W-1:0]     cfg_wr_data,
    input logic [NPINS-1:0]     own_mask,
    input logic [NPINS-1:0]     pad_oe,
    input logic [NPINS-1:0]     pad_pu,
    input logic [NPINS-1:0]     pad_pd,
    input logic [NPINS-1:0]     pad_i,
    input logic [NPINS-1:0]     dbg_in,
    input logic [NPINS-1:0]     gpio_in
);

    // R2
    a_r2_wire_release: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_wr_data == CFG_WIRE) |=> (own_mask == MASK_WIRE));

    // R6
    a_r6_free_release: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_wr_data == CFG_FREE) |=> (own_mask == MASK_NONE));

    // R7
    a_r7_other_full: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_wr_data != CFG_FREE && cfg_wr_data != CFG_WIRE)
        |=> (own_mask == MASK_ALL));

    // R7: ownership holds without a selection write
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr_en |=> $stable(own_mask));

    // R5
    a_r5_core_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (own_mask != MASK_NONE) |-> (own_mask[PIN_MSEL] && own_mask[PIN_DCLK]));

    // R3
    a_r3_dclk_pulldown: assert property (@(posedge clk) disable iff (!rst_n)
        own_mask[PIN_DCLK] |-> (pad_pd[PIN_DCLK] && !pad_pu[PIN_DCLK] && !pad_oe[PIN_DCLK]));

    a_r3_trst_pullup: assert property (@(posedge clk) disable iff (!rst_n)
        own_mask[PIN_TRST] |-> (pad_pu[PIN_TRST] && !pad_pd[PIN_TRST] && !pad_oe[PIN_TRST]));

    a_r3_din_pullup: assert property (@(posedge clk) disable iff (!rst_n)
        own_mask[PIN_DIN] |-> (pad_pu[PIN_DIN] && !pad_pd[PIN_DIN] && !pad_oe[PIN_DIN]));

    a_r3_msel_pullup: assert property (@(posedge clk) disable iff (!rst_n)
        own_mask[PIN_MSEL] |-> (pad_pu[PIN_MSEL] && !pad_pd[PIN_MSEL]));

    // R10
    for (genvar p = 0; p < NPINS; p++) begin : g_route
        a_r10_route: assert property (@(posedge clk) disable iff (!rst_n)
            own_mask[p] ? (dbg_in[p] == pad_i[p] && !gpio_in[p])
                        : (gpio_in[p] == pad_i[p]));
    end

endmodule

bind dbg_pin_share_ctrl dps_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_data (cfg_wr_data),
    .own_mask    (own_mask),
    .pad_oe      (pad_oe),
    .pad_pu      (pad_pu),
    .pad_pd      (pad_pd),
    .pad_i       (pad_i),
    .dbg_in      (dbg_in),
    .gpio_in     (gpio_in)
);

// File: tb/dbg_pin_share_ctrl_tb_top.sv
module dbg_pin_share_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr_en = 1'b0;
    logic [2:0] cfg_wr_data = 3'b000;
    logic [4:0] gpio_wr_en = '0;
    logic [1:0] gpio_mode_wr = 2'b00;
    logic       gpio_out_wr = 1'b0;
    logic       dbg_dout = 1'b0;
    logic       dbg_dout_oe = 1'b0;
    logic       dbg_swd_o = 1'b0;
    logic       dbg_swd_oe = 1'b0;
    logic [4:0] pad_i = '0;
    logic [4:0] pad_oe, pad_o, pad_pu, pad_pd, dbg_in, gpio_in;

    int vectors = 0;
    int fails = 0;

    // Reference model: 0 = all debug, 1 = serial-wire only, 2 = all GPIO
    int       m_state = 0;
    int       m_mode [5];
    bit       m_out  [5];

    always #4 clk = ~clk;  // 125 MHz

    dbg_pin_share_ctrl dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr_en    (cfg_wr_en),
        .cfg_wr_data  (cfg_wr_data),
        .gpio_wr_en   (gpio_wr_en),
        .gpio_mode_wr (gpio_mode_wr),
        .gpio_out_wr  (gpio_out_wr),
        .dbg_dout     (dbg_dout),
        .dbg_dout_oe  (dbg_dout_oe),
        .dbg_swd_o    (dbg_swd_o),
        .dbg_swd_oe   (dbg_swd_oe),
        .pad_i        (pad_i),
        .pad_oe       (pad_oe),
        .pad_o        (pad_o),
        .pad_pu       (pad_pu),
        .pad_pd       (pad_pd),
        .dbg_in       (dbg_in),
        .gpio_in      (gpio_in)
    );

    function automatic bit owned(int i);
        return (m_state == 0) || (m_state == 1 && i < 2);
    endfunction

    task automatic check_vec(string what, string req, logic [4:0] act, logic [4:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic compare(string req);
        logic [4:0] e_oe, e_o, e_pu, e_pd, e_dbg, e_gin;
        for (int i = 0; i < 5; i++) begin
            if (owned(i)) begin
                e_dbg[i] = pad_i[i];
                e_gin[i] = 1'b0;
                case (i)
                    0: begin
                        e_oe[i] = (m_state == 1) ? dbg_swd_oe : 1'b0;
                        e_o[i]  = (m_state == 1) ? dbg_swd_o  : 1'b0;
                        e_pu[i] = 1'b1; e_pd[i] = 1'b0;
                    end
                    1: begin
                        e_oe[i] = 1'b0; e_o[i] = 1'b0; e_pu[i] = 1'b0; e_pd[i] = 1'b1;
                    end
                    3: begin
                        e_oe[i] = dbg_dout_oe; e_o[i] = dbg_dout;
                        e_pu[i] = 1'b0; e_pd[i] = 1'b0;
                    end
                    default: begin
                        e_oe[i] = 1'b0; e_o[i] = 1'b0; e_pu[i] = 1'b1; e_pd[i] = 1'b0;
                    end
                endcase
            end else begin
                e_oe[i]  = (m_mode[i] == 3);
                e_o[i]   = (m_mode[i] == 3) && m_out[i];
                e_pu[i]  = (m_mode[i] == 1);
                e_pd[i]  = (m_mode[i] == 2);
                e_dbg[i] = (i != 1 && i != 3);
                e_gin[i] = pad_i[i];
            end
        end
        check_vec("pad_oe",  req, pad_oe,  e_oe);
        check_vec("pad_o",   req, pad_o,   e_o);
        check_vec("pad_pu",  req, pad_pu,  e_pu);
        check_vec("pad_pd",  req, pad_pd,  e_pd);
        check_vec("dbg_in",  req, dbg_in,  e_dbg);
        check_vec("gpio_in", req, gpio_in, e_gin);
    endtask

    // Drive at a falling edge, capture at the rising edge, compare at the next falling edge
    task automatic step(bit cwe, logic [2:0] cd, logic [4:0] gwe, logic [1:0] gm,
                        bit go, logic [3:0] dbgv, logic [4:0] pad, string req);
        cfg_wr_en    = cwe;
        cfg_wr_data  = cd;
        gpio_wr_en   = gwe;
        gpio_mode_wr = gm;
        gpio_out_wr  = go;
        {dbg_swd_oe, dbg_swd_o, dbg_dout_oe, dbg_dout} = dbgv;
        pad_i        = pad;
        @(posedge clk);
        for (int i = 0; i < 5; i++) begin
            if (gwe[i]) begin
                m_mode[i] = int'(gm);
                m_out[i]  = go;
            end
        end
        if (cwe) m_state = (cd == 3'b010) ? 1 : (cd == 3'b100) ? 2 : 0;
        @(negedge clk);
        compare(req);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int v;
        v = 0;
        for (int i = 0; i < 5; i++) begin
            m_mode[i] = 0;
            m_out[i]  = 1'b0;
        end

        // R1: reset state, with GPIO writes attempted during reset
        gpio_wr_en = 5'h1f; gpio_mode_wr = 2'b11; gpio_out_wr = 1'b1;
        pad_i = 5'b10110; dbg_dout_oe = 1'b1; dbg_dout = 1'b1;
        repeat (3) @(negedge clk);
        compare("R1");
        gpio_wr_en = '0;
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1");
        step(1'b0, 3'b000, 5'h00, 2'b00, 1'b0, 4'b0011, 5'b01001, "R1");
        step(1'b0, 3'b000, 5'h00, 2'b00, 1'b0, 4'b1100, 5'b11111, "R11");

        // R4: GPIO writes to debug-owned pads have no pad effect
        for (int p = 0; p < 5; p++)
            for (int m = 0; m < 4; m++)
                for (int o = 0; o < 2; o++) begin
                    v++;
                    step(1'b0, 3'b000, 5'(1 << p), 2'(m), 1'(o), 4'(v), 5'(v * 7), "R4");
                end

        // R8: last stored settings take effect on the release edge
        step(1'b0, 3'b000, 5'b10101, 2'b11, 1'b1, 4'b0000, 5'b00000, "R4");
        step(1'b0, 3'b000, 5'b01010, 2'b10, 1'b0, 4'b0000, 5'b00000, "R4");
        step(1'b1, 3'b100, 5'h00, 2'b00, 1'b0, 4'b1111, 5'b10101, "R8");
        step(1'b1, 3'b000, 5'h00, 2'b00, 1'b0, 4'b0101, 5'b01010, "R7");
        // same-edge GPIO write and release
        step(1'b1, 3'b010, 5'b00100, 2'b11, 1'b1, 4'b1010, 5'b00000, "R8");
        step(1'b1, 3'b000, 5'b10000, 2'b01, 1'b0, 4'b0000, 5'b00000, "R8");
        step(1'b1, 3'b010, 5'h00, 2'b00, 1'b0, 4'b0000, 5'b11111, "R8");

        // R2 R5 R6 R7: every transition between selection values
        for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b++) begin
                v++;
                step(1'b1, 3'(a), 5'(v), 2'(v), 1'(v >> 1), 4'(v * 3), 5'(v * 5), "R7");
                step(1'b1, 3'(b), 5'h00, 2'b00, 1'b0, 4'(v * 11), 5'(v * 13),
                     (b == 2) ? "R2" : (b == 4) ? "R6" : "R7");
            end

        // R9 R10 R3 R5 R11: GPIO encoding sweep under each ownership mode
        for (int c = 0; c < 3; c++) begin
            step(1'b1, (c == 0) ? 3'b000 : (c == 1) ? 3'b010 : 3'b100,
                 5'h00, 2'b00, 1'b0, 4'b0000, 5'b00000, "R3");
            for (int p = 0; p < 5; p++)
                for (int m = 0; m < 4; m++)
                    for (int o = 0; o < 2; o++) begin
                        v++;
                        step(1'b0, 3'b000, 5'(1 << p), 2'(m), 1'(o), 4'(v), 5'(v * 9),
                             (c == 2) ? "R9" : (c == 1) ? "R5" : "R11");
                        step(1'b0, 3'b000, 5'h00, 2'b00, 1'b0, 4'(~v), 5'(~(v * 9)), "R10");
                    end
        end

        summary();
        $finish;
    end

endmodule